// File: doc/BRIEF.md
# Atomic Set-Bit Memory Bank

This block is one bank of word-wide storage that sits behind a bus request port and serves three kinds of request: a plain word read, a byte-masked write, and an atomic set-bit operation used for software locks. The set-bit operation runs entirely inside the bank as a read-modify-write. It fetches the addressed word, reports the previous value of one selected bit, forces that bit to one and writes the word back. No other request can reach the storage between the fetch and the write-back. No separate lock unit exists anywhere in the system, because the bank itself provides the atomicity.

A requester raises `req_valid` with an opcode, a word address and the operands. The bank takes the request on the first rising edge where `req_ready` is high, then keeps `req_ready` low while the operation is in progress. A plain access occupies the bank for 4 clocks. A set-bit occupies it for 8 clocks. Completion is a single-cycle `rsp_done` pulse, with `rsp_rdata` and `rsp_flag` valid in that cycle. A cleared flag tells the requester that it now holds the lock. A lock is released with an ordinary byte-masked write that clears the bit. Waiting for a lock with a plain read costs only the short cycle.

Top module: `ilk_bank`

## Requirements
- R1: Opcode encoding on `req_op`: 2'b00 read, 2'b01 write, 2'b10 set-bit, 2'b11 probe. A probe behaves exactly like a read. A read or probe returns the full addressed word on `rsp_rdata`, and `rsp_done` is high in the cycle right after the 4th rising edge following the accepting edge.
- R2: A write updates only the byte lanes whose `req_be` bit is set (lane n is data bits 8n+7..8n) and leaves the other lanes unchanged. It completes on the same 4-edge timing as a read, with `rsp_rdata` = 0 and `rsp_flag` = 0.
- R3: A set-bit completes in the cycle right after the 8th rising edge following the accepting edge. It returns the word as it was before the operation on `rsp_rdata`, and the previous value of bit `req_lane`*8+`req_bit` on `rsp_flag`.
- R4: A set-bit forces that one bit to 1 and leaves all other bits of the word unchanged.
- R5: `req_ready` is low from the accepting edge until the completion edge: 4 cycles for read, write and probe, 8 cycles for set-bit. A request that is held pending during that time is accepted on the first edge after completion. For a set-bit this is 9 edges after the earlier acceptance.
- R6: `rsp_flag` is 0 in every cycle except the completion cycle of a set-bit. `rsp_rdata` is 0 in every cycle where `rsp_done` is low.
- R7: After reset, `req_ready` = 1, `rsp_done` = 0, `rsp_flag` = 0, and every stored word reads as 0.
- R8: After a write clears a lock bit, the next set-bit on that bit reports flag 0.
- R9: Two back-to-back set-bits on different lanes of the same word both take effect. The second one returns a word that already contains the bit set by the first.
- R10: Every accepted request produces exactly one single-cycle `rsp_done` pulse, and `rsp_done` never rises without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank idle; request taken on this edge if valid |
| req_op | input | 2 | Opcode (read, write, set-bit, probe) |
| req_addr | input | ADDR_W (6) | Word address |
| req_lane | input | log2(DATA_W/8) (2) | Byte lane of the lock bit |
| req_bit | input | 3 | Bit within the lane |
| req_wdata | input | DATA_W (32) | Write data |
| req_be | input | DATA_W/8 (4) | Byte enables for writes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (32) | Word read (prior word for set-bit) |
| rsp_flag | output | 1 | Prior value of the set bit |

## Verification
Each result has a fixed due time. A read, write or probe completes on the 4th clock edge after the edge that accepted it, and a set-bit completes on the 8th. When the driver issues a request, it records the number of the cycle whose edge accepts it. The scoreboard monitor samples on falling edges and checks that `rsp_done` shows up exactly 4 or 8 cycles after that recorded edge, and that the data and flag match a reference word image kept by the bench. Separate probes count how many cycles `req_ready` stays low after an acceptance, and measure the gap in accepting edges when a second request waits behind a set-bit. Together these probes confirm the hold-off that makes the set-bit atomic.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [1:0] {
      OP_RD  = 2'b00,
      OP_WR  = 2'b01,
      OP_SET = 2'b10,
      OP_PRB = 2'b11
   } ilk_op_e;

   function automatic logic op_is_rmw(input ilk_op_e op);
      return op == OP_SET;
   endfunction

   function automatic logic op_writes(input ilk_op_e op);
      return (op == OP_WR) || (op == OP_SET);
   endfunction

endpackage

// File: rtl/ilk_seq.sv
module ilk_seq #(
   parameter int RD_CYC  = 4,
   parameter int RMW_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_rmw,
   output logic busy,
   output logic fetch,
   output logic finish
);
   localparam int CNT_W = $clog2(RMW_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         first_q <= 1'b0;
      end else begin
         first_q <= start;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= is_rmw ? CNT_W'(RMW_CYC - 1) : CNT_W'(RD_CYC - 1);
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assign busy   = busy_q;
   assign fetch  = first_q;
   assign finish = busy_q && (cnt_q == '0);
endmodule

// File: rtl/ilk_store.sv
module ilk_store #(
   parameter int DATA_W         = 32,
   parameter int ADDR_W         = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [DATA_W/8-1:0] wbe,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int w = 0; w < DEPTH; w++) mem[w] <= 8'h00;
            end else if (we && wbe[l]) begin
               mem[addr] <= wdata[l*8 +: 8];
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && wbe[l]) mem[addr] <= wdata[l*8 +: 8];
         end
      end

      assign rdata[l*8 +: 8] = mem[addr];
   end
endmodule

// File: rtl/ilk_merge.sv
module ilk_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]              old_word,
   input  logic [$clog2(DATA_W/8)-1:0]    lane,
   input  logic [2:0]                     bitn,
   output logic [DATA_W-1:0]              new_word,
   output logic                           prior
);
   localparam int POS_W = $clog2(DATA_W);

   logic [POS_W-1:0]  pos;
   logic [DATA_W-1:0] mask;

   always_comb begin
      pos      = {lane, bitn};
      mask     = '0;
      mask[pos] = 1'b1;
      new_word = old_word | mask;
      prior    = old_word[pos];
   end
endmodule

// File: rtl/ilk_bank.sv
module ilk_bank #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6,
   parameter int RD_CYC  = 4,
   parameter int RMW_CYC = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [1:0]                    req_op,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [$clog2(DATA_W/8)-1:0]   req_lane,
   input  logic [2:0]                    req_bit,
   input  logic [DATA_W-1:0]             req_wdata,
   input  logic [DATA_W/8-1:0]           req_be,
   output logic                          rsp_done,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic                          rsp_flag
);
   import ilk_pkg::*;

   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   if ((DATA_W % 8) != 0 || DATA_W < 16 || (1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_width
      $error("ilk_bank: DATA_W must be a power of two of at least 16");
   end
   if (RD_CYC < 2) begin : g_bad_rd
      $error("ilk_bank: RD_CYC must be at least 2");
   end
   if (RMW_CYC <= RD_CYC) begin : g_bad_rmw
      $error("ilk_bank: RMW_CYC must exceed RD_CYC");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("ilk_bank: ADDR_W out of range");
   end

   ilk_op_e              op_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [LANE_W-1:0]    lane_q;
   logic [2:0]           bit_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [LANES-1:0]     be_q;
   logic [DATA_W-1:0]    hold_q;

   logic                 busy, fetch, finish, start;
   logic [DATA_W-1:0]    st_rdata, st_wdata, merged;
   logic [LANES-1:0]     st_wbe;
   logic                 st_we, prior;
   ilk_op_e              in_op;

   assign in_op     = ilk_op_e'(req_op);
   assign req_ready = !busy;
   assign start     = req_valid && !busy;

   ilk_seq #(.RD_CYC(RD_CYC), .RMW_CYC(RMW_CYC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .is_rmw (op_is_rmw(in_op)),
      .busy   (busy),
      .fetch  (fetch),
      .finish (finish)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_RD;
         addr_q  <= '0;
         lane_q  <= '0;
         bit_q   <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         hold_q  <= '0;
      end else begin
         if (start) begin
            op_q    <= in_op;
            addr_q  <= req_addr;
            lane_q  <= req_lane;
            bit_q   <= req_bit;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         if (fetch) hold_q <= st_rdata;
      end
   end

   ilk_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word (hold_q),
      .lane     (lane_q),
      .bitn     (bit_q),
      .new_word (merged),
      .prior    (prior)
   );

   always_comb begin
      st_we    = finish && op_writes(op_q);
      st_wbe   = op_is_rmw(op_q) ? '1 : be_q;
      st_wdata = op_is_rmw(op_q) ? merged : wdata_q;
   end

   ilk_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLEAR_ON_RESET(1'b1)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr_q),
      .we    (st_we),
      .wbe   (st_wbe),
      .wdata (st_wdata),
      .rdata (st_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
         rsp_flag  <= 1'b0;
      end else begin
         rsp_done  <= finish;
         rsp_rdata <= (finish && op_q != OP_WR) ? hold_q : '0;
         rsp_flag  <= finish && op_is_rmw(op_q) && prior;
      end
   end
endmodule

// File: rtl/ilk_bank_chk.sv
module ilk_bank_chk #(
   parameter int DATA_W  = 32,
   parameter int RD_CYC  = 4,
   parameter int RMW_CYC = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic              rsp_done,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_flag
);
   logic        acc;
   logic        pend_q;
   logic        set_q;
   logic [15:0] lat_q;
   logic [15:0] exp_q;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         set_q  <= 1'b0;
         lat_q  <= '0;
         exp_q  <= '0;
      end else if (acc) begin
         pend_q <= 1'b1;
         set_q  <= (req_op == ilk_pkg::OP_SET);
         lat_q  <= '0;
         exp_q  <= (req_op == ilk_pkg::OP_SET) ? 16'(RMW_CYC) : 16'(RD_CYC);
      end else if (rsp_done) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   // R5
   busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !req_ready);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R10
   done_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> pend_q);

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (lat_q == exp_q));

   // R6
   flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_done || !set_q) |-> !rsp_flag);

   // R6
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> (rsp_rdata == '0));
endmodule

bind ilk_bank ilk_bank_chk #(.DATA_W(DATA_W), .RD_CYC(RD_CYC), .RMW_CYC(RMW_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata),
   .rsp_flag  (rsp_flag)
);

// File: tb/ilk_bank_tb.sv
module ilk_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'b00;
   logic [5:0]  req_addr = '0;
   logic [1:0]  req_lane = '0;
   logic [2:0]  req_bit = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic        rsp_flag;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int last_acc = 0;
   int prev_acc = 0;
   bit finished = 0;

   logic [31:0] model [64];
   logic [31:0] q_rd [$];
   logic        q_fl [$];
   int          q_lat [$];
   int          q_acc [$];
   string       q_tag [$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ilk_bank u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_lane(req_lane), .req_bit(req_bit),
      .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .rsp_flag(rsp_flag)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [1:0] ln,
                        input logic [2:0] bn, input logic [31:0] wd, input logic [3:0] be,
                        input string tag);
      logic [31:0] old, nw;
      logic [31:0] erd;
      logic        efl;
      int          elat;
      int          pos;
      old = model[a];
      nw = old;
      erd = old;
      efl = 1'b0;
      elat = 4;
      if (op == 2'b01) begin
         for (int l = 0; l < 4; l++) if (be[l]) nw[l*8 +: 8] = wd[l*8 +: 8];
         erd = '0;
      end else if (op == 2'b10) begin
         pos = int'(ln) * 8 + int'(bn);
         efl = old[pos];
         nw[pos] = 1'b1;
         elat = 8;
      end
      model[a] = nw;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_lane = ln; req_bit = bn;
      req_wdata = wd; req_be = be;
      while (!req_ready) @(negedge clk);
      prev_acc = last_acc;
      last_acc = cyc + 1;
      q_rd.push_back(erd); q_fl.push_back(efl); q_lat.push_back(elat);
      q_acc.push_back(last_acc); q_tag.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rsp_done) begin
            if (q_rd.size() == 0) begin
               chk("R10 unexpected done", 32'd1, 32'd0);
            end else begin
               string t;
               int    a;
               t = q_tag.pop_front();
               a = q_acc.pop_front();
               chk({t, " rdata"}, rsp_rdata, q_rd.pop_front());
               chk({t, " flag"}, {31'd0, rsp_flag}, {31'd0, q_fl.pop_front()});
               chk({t, " latency"}, 32'(cyc - a), 32'(q_lat.pop_front()));
            end
         end else begin
            if (rsp_flag !== 1'b0) chk("R6 flag while idle", {31'd0, rsp_flag}, 32'd0);
            if (rsp_rdata !== 32'd0) chk("R6 rdata while idle", rsp_rdata, 32'd0);
         end
      end
   end

   task automatic probe_busy(input int exp, input string tag);
      int n = 0;
      while (!req_ready) begin n++; @(negedge clk); end
      chk(tag, 32'(n), 32'(exp));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      chk("R7 ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R7 done after reset", {31'd0, rsp_done}, 32'd0);
      chk("R7 flag after reset", {31'd0, rsp_flag}, 32'd0);

      issue(2'b00, 6'd5, 2'd0, 3'd0, 32'h0, 4'h0, "R7 R1 read cleared word");
      issue(2'b01, 6'd5, 2'd0, 3'd0, 32'hA5A5_5A5A, 4'hF, "R2 full write");
      issue(2'b00, 6'd5, 2'd0, 3'd0, 32'h0, 4'h0, "R1 read after write");
      issue(2'b01, 6'd5, 2'd0, 3'd0, 32'hFFFF_FFFF, 4'b0010, "R2 lane1 write");
      issue(2'b00, 6'd5, 2'd0, 3'd0, 32'h0, 4'h0, "R2 read partial");
      probe_busy(4, "R5 read occupancy");

      issue(2'b10, 6'd9, 2'd2, 3'd5, 32'h0, 4'h0, "R3 lock free bit");
      probe_busy(8, "R5 lock occupancy");
      issue(2'b00, 6'd9, 2'd0, 3'd0, 32'h0, 4'h0, "R4 read locked word");
      issue(2'b10, 6'd9, 2'd2, 3'd5, 32'h0, 4'h0, "R3 lock held bit");

      issue(2'b10, 6'd9, 2'd0, 3'd0, 32'h0, 4'h0, "R9 lock lane0");
      issue(2'b10, 6'd9, 2'd3, 3'd7, 32'h0, 4'h0, "R9 lock lane3 back to back");
      chk("R5 held request accepted after lock", 32'(last_acc - prev_acc), 32'd9);
      issue(2'b00, 6'd9, 2'd0, 3'd0, 32'h0, 4'h0, "R9 read both bits");

      issue(2'b10, 6'd5, 2'd0, 3'd0, 32'h0, 4'h0, "R4 lock clear bit in data word");
      issue(2'b10, 6'd5, 2'd0, 3'd1, 32'h0, 4'h0, "R4 lock already set bit");
      issue(2'b00, 6'd5, 2'd0, 3'd0, 32'h0, 4'h0, "R4 other bits kept");

      issue(2'b01, 6'd9, 2'd0, 3'd0, 32'h0, 4'b0100, "R8 release write");
      issue(2'b10, 6'd9, 2'd2, 3'd5, 32'h0, 4'h0, "R8 relock after release");
      issue(2'b11, 6'd9, 2'd0, 3'd0, 32'h0, 4'h0, "R1 probe opcode");
      issue(2'b00, 6'd40, 2'd0, 3'd0, 32'h0, 4'h0, "R7 untouched word");

      repeat (20) @(negedge clk);
      chk("R10 all responses seen", 32'(q_rd.size()), 32'd0);
      finish_run();
   end
endmodule